// File: doc/BRIEF.md
# MOESI Line State Controller

This block keeps the coherence state of a single line in a copy-back cache and decides, for each event, where that state goes next and what the cache must put on the shared bus. The state is held as three attribute bits: valid, exclusive and owned. Five legal combinations of those bits form the states Modified, Owned, Exclusive, Shareable and Invalid.

Two kinds of event arrive. The first is a processor operation: a read, a write, a write-back that keeps the line, or a write-back that drops it. For these the block drives the master qualifiers (caching master, intent to modify, broadcast) and names the bus transaction to run. It samples the shared-hit line from the other caches during that same cycle. The second is a snooped transaction, described by the other master's three qualifiers. For these the block raises the shared-hit, intervention and select responses. Each event is resolved within its cycle, and the state register takes the result at the next clock edge.

A mode word can replace a preferred result with a legal but weaker one. It can demote exclusive to shareable or modified to owned, invalidate others instead of broadcasting the write, and invalidate instead of updating on snooped broadcast writes.

Top module: `moesi_line_ctrl`

## Requirements
- R1: `state_o` is {valid, exclusive, owned}: Modified=111, Owned=101, Exclusive=110, Shareable=100, Invalid=000. Reset leaves the line Invalid.
- R2: `lcl_op`=0 is a read. On a miss it drives caching-master only, `req_txn`=1 (read), and ends in Shareable if `bus_ch_in` is high, otherwise Exclusive. On a hit it drives nothing and keeps the state.
- R3: `lcl_op`=1 is a write. On a hit, Modified and Exclusive end in Modified with no bus activity. From Owned or Shareable with `mode_i[2]`=0 it drives all three qualifiers and `req_txn`=2 (write), and ends in Owned if `bus_ch_in` is high, otherwise Modified. With `mode_i[2]`=1 it drives caching master and intent to modify, `req_txn`=3 (claim), and ends in Modified.
- R4: A write miss drives caching master and intent to modify, `req_txn`=1 (read), and ends in Modified.
- R5: `lcl_op`=2 keeps the line after a write-back. Modified ends in Exclusive. Owned ends in Shareable if `bus_ch_in` is high, otherwise Exclusive. Both drive caching master and `req_txn`=2. `lcl_op`=3 drops the line: it always ends Invalid, and Modified and Owned issue `req_txn`=2 with no qualifiers. In every other state these operations cause no bus activity.
- R6: A snooped read (`snp_im`=0, `snp_bc` ignored) raises `rsp_ch` from any valid line and `rsp_di` from an owned line. For a caching reader, owned lines end in Owned and unowned lines end in Shareable. For a non-caching reader the state is unchanged.
- R7: A snooped read-for-modify (CA=1, IM=1, BC=0) raises `rsp_di` from an owned line and invalidates every valid line.
- R8: A snooped non-caching write (CA=0, IM=1, BC=0) raises `rsp_di` from an owned line and leaves it unchanged. Unowned lines become Invalid.
- R9: A snooped broadcast write (IM=1, BC=1) from a non-caching master makes an owned line raise `rsp_di` and keep its state. In every other case a valid line ends in Shareable with `rsp_sl` and `rsp_ch`. If `mode_i[3]`=1 it instead ends Invalid with no response.
- R10: When `snp_valid` and `lcl_valid` are both high, the snoop is processed and the local request is ignored: no qualifiers are driven and `req_txn`=0.
- R11: `mode_i[0]` turns any resulting Exclusive into Shareable, and `mode_i[1]` turns any resulting Modified into Owned.
- R12: With no event, the state holds and every bus output is 0. An Invalid line gives no response to any snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Processor operation present |
| lcl_op | input | 2 | 0 read, 1 write, 2 write-back keep, 3 write-back drop |
| bus_ch_in | input | 1 | Shared-hit seen from other caches during the local transaction |
| snp_valid | input | 1 | Snooped transaction present |
| snp_ca | input | 1 | Snooped master is caching |
| snp_im | input | 1 | Snooped master intends to modify |
| snp_bc | input | 1 | Snooped master broadcasts its data |
| mode_i | input | 4 | [0] demote E, [1] demote M, [2] invalidate-on-write, [3] invalidate-on-snoop |
| state_o | output | 3 | Current state {valid, exclusive, owned} |
| next_state_o | output | 3 | State taken at the next edge |
| req_ca | output | 1 | Drive caching-master qualifier |
| req_im | output | 1 | Drive intent-to-modify qualifier |
| req_bc | output | 1 | Drive broadcast qualifier |
| req_txn | output | 2 | 0 none, 1 read, 2 write, 3 address-only claim |
| rsp_ch | output | 1 | Shared-hit response |
| rsp_di | output | 1 | Intervention response |
| rsp_sl | output | 1 | Select response (connect to update) |

## Verification
The bench builds the block with `ALLOW_DEGRADE`=1, so all four mode bits reach the transition logic. That makes the demoted results and the invalidate alternatives reachable alongside the preferred entries. Random mode words are mixed with random local and snooped events. This drives the line through every state under both shared-hit polarities and under colliding events.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef struct packed {
        logic valid;
        logic excl;
        logic owned;
    } line_st_t;

    localparam line_st_t ST_M = '{valid: 1'b1, excl: 1'b1, owned: 1'b1};
    localparam line_st_t ST_O = '{valid: 1'b1, excl: 1'b0, owned: 1'b1};
    localparam line_st_t ST_E = '{valid: 1'b1, excl: 1'b1, owned: 1'b0};
    localparam line_st_t ST_S = '{valid: 1'b1, excl: 1'b0, owned: 1'b0};
    localparam line_st_t ST_I = '{valid: 1'b0, excl: 1'b0, owned: 1'b0};

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_KEEP = 2'd2,
        OP_DROP = 2'd3
    } lcl_op_e;

    typedef enum logic [1:0] {
        TX_NONE  = 2'd0,
        TX_READ  = 2'd1,
        TX_WRITE = 2'd2,
        TX_CLAIM = 2'd3
    } txn_e;

    localparam int MODE_W = 4;

    typedef struct packed {
        logic snp_inval;
        logic wr_inval;
        logic demote_m;
        logic demote_e;
    } mode_t;

    typedef struct packed {
        logic ca;
        logic im;
        logic bc;
        txn_e txn;
    } bus_req_t;

    typedef struct packed {
        logic ch;
        logic di;
        logic sl;
    } snp_rsp_t;

    function automatic line_st_t apply_demote(line_st_t s, mode_t m);
        line_st_t r;
        r = s;
        if (m.demote_e && s == ST_E) r = ST_S;
        if (m.demote_m && s == ST_M) r = ST_O;
        return r;
    endfunction

endpackage

// File: rtl/moesi_local_fsm.sv
module moesi_local_fsm
    import moesi_pkg::*;
(
    input  line_st_t st,
    input  lcl_op_e  op,
    input  logic     ch,
    input  mode_t    mode,
    output line_st_t nxt,
    output bus_req_t req
);
    line_st_t raw;

    always_comb begin
        raw = st;
        req = '{ca: 1'b0, im: 1'b0, bc: 1'b0, txn: TX_NONE};
        unique case (op)
            OP_RD: begin
                if (!st.valid) begin
                    req.ca  = 1'b1;
                    req.txn = TX_READ;
                    raw     = ch ? ST_S : ST_E;
                end
            end
            OP_WR: begin
                if (!st.valid) begin
                    req.ca  = 1'b1;
                    req.im  = 1'b1;
                    req.txn = TX_READ;
                    raw     = ST_M;
                end else if (st.excl) begin
                    raw = ST_M;
                end else if (mode.wr_inval) begin
                    req.ca  = 1'b1;
                    req.im  = 1'b1;
                    req.txn = TX_CLAIM;
                    raw     = ST_M;
                end else begin
                    req.ca  = 1'b1;
                    req.im  = 1'b1;
                    req.bc  = 1'b1;
                    req.txn = TX_WRITE;
                    raw     = ch ? ST_O : ST_M;
                end
            end
            OP_KEEP: begin
                if (st.owned) begin
                    req.ca  = 1'b1;
                    req.txn = TX_WRITE;
                    raw     = (st.excl || !ch) ? ST_E : ST_S;
                end
            end
            default: begin
                if (st.owned) req.txn = TX_WRITE;
                raw = ST_I;
            end
        endcase
        nxt = apply_demote(raw, mode);
    end
endmodule

// File: rtl/moesi_snoop_fsm.sv
module moesi_snoop_fsm
    import moesi_pkg::*;
(
    input  line_st_t st,
    input  logic     ca,
    input  logic     im,
    input  logic     bc,
    input  mode_t    mode,
    output line_st_t nxt,
    output snp_rsp_t rsp
);
    line_st_t raw;

    always_comb begin
        raw = st;
        rsp = '0;
        if (st.valid) begin
            if (!im) begin
                rsp.ch = 1'b1;
                rsp.di = st.owned;
                if (ca) raw = st.owned ? ST_O : ST_S;
            end else if (!bc) begin
                if (st.owned) rsp.di = 1'b1;
                if (ca || !st.owned) raw = ST_I;
            end else if (!ca && st.owned) begin
                rsp.di = 1'b1;
            end else if (mode.snp_inval) begin
                raw = ST_I;
            end else begin
                raw    = ST_S;
                rsp.sl = 1'b1;
                rsp.ch = 1'b1;
            end
        end
        nxt = apply_demote(raw, mode);
    end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter bit ALLOW_DEGRADE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lcl_valid,
    input  logic [1:0]  lcl_op,
    input  logic        bus_ch_in,
    input  logic        snp_valid,
    input  logic        snp_ca,
    input  logic        snp_im,
    input  logic        snp_bc,
    input  logic [3:0]  mode_i,
    output logic [2:0]  state_o,
    output logic [2:0]  next_state_o,
    output logic        req_ca,
    output logic        req_im,
    output logic        req_bc,
    output logic [1:0]  req_txn,
    output logic        rsp_ch,
    output logic        rsp_di,
    output logic        rsp_sl
);
    line_st_t state_q, state_d, lcl_nxt, snp_nxt;
    bus_req_t lcl_req, req;
    snp_rsp_t snp_rsp, rsp;
    mode_t    mode_eff;

    generate
        if (ALLOW_DEGRADE) begin : g_mode
            assign mode_eff = mode_t'(mode_i[MODE_W-1:0]);
        end else begin : g_fixed
            assign mode_eff = '0;
        end
    endgenerate

    moesi_local_fsm u_local (
        .st   (state_q),
        .op   (lcl_op_e'(lcl_op)),
        .ch   (bus_ch_in),
        .mode (mode_eff),
        .nxt  (lcl_nxt),
        .req  (lcl_req)
    );

    moesi_snoop_fsm u_snoop (
        .st   (state_q),
        .ca   (snp_ca),
        .im   (snp_im),
        .bc   (snp_bc),
        .mode (mode_eff),
        .nxt  (snp_nxt),
        .rsp  (snp_rsp)
    );

    always_comb begin
        state_d = state_q;
        req     = '{ca: 1'b0, im: 1'b0, bc: 1'b0, txn: TX_NONE};
        rsp     = '0;
        if (snp_valid) begin
            state_d = snp_nxt;
            rsp     = snp_rsp;
        end else if (lcl_valid) begin
            state_d = lcl_nxt;
            req     = lcl_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_I;
        else     state_q <= state_d;
    end

    assign state_o      = state_q;
    assign next_state_o = state_d;
    assign req_ca       = req.ca;
    assign req_im       = req.im;
    assign req_bc       = req.bc;
    assign req_txn      = req.txn;
    assign rsp_ch       = rsp.ch;
    assign rsp_di       = rsp.di;
    assign rsp_sl       = rsp.sl;

    a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
        !state_q.valid |-> (!state_q.excl && !state_q.owned));

    a_r6_di_from_owner: assert property (@(posedge clk) disable iff (rst)
        rsp_di |-> (snp_valid && state_q.owned));

    a_r10_snoop_blocks_local: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> (!req_ca && !req_im && !req_bc && req_txn == 2'd0));

    a_r7_rfm_invalidates: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_ca && snp_im && !snp_bc) |=> !state_q.valid);

    a_r4_write_owns: assert property (@(posedge clk) disable iff (rst)
        (lcl_valid && !snp_valid && lcl_op == 2'd1) |=> state_q.owned);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!snp_valid && !lcl_valid) |=> $stable(state_q));
endmodule

// File: tb/moesi_line_ctrl_tb.sv
module moesi_line_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       lcl_valid, bus_ch_in, snp_valid, snp_ca, snp_im, snp_bc;
    logic [1:0] lcl_op;
    logic [3:0] mode_i;
    logic [2:0] state_o, next_state_o;
    logic       req_ca, req_im, req_bc, rsp_ch, rsp_di, rsp_sl;
    logic [1:0] req_txn;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [2:0] mstate;

    localparam logic [2:0] M = 3'b111, O = 3'b101, E = 3'b110, S = 3'b100, I = 3'b000;

    always #2 clk = ~clk;

    moesi_line_ctrl u_dut (
        .clk(clk), .rst(rst), .lcl_valid(lcl_valid), .lcl_op(lcl_op),
        .bus_ch_in(bus_ch_in), .snp_valid(snp_valid), .snp_ca(snp_ca),
        .snp_im(snp_im), .snp_bc(snp_bc), .mode_i(mode_i),
        .state_o(state_o), .next_state_o(next_state_o), .req_ca(req_ca),
        .req_im(req_im), .req_bc(req_bc), .req_txn(req_txn),
        .rsp_ch(rsp_ch), .rsp_di(rsp_di), .rsp_sl(rsp_sl)
    );

    function automatic logic [2:0] dem(logic [2:0] s, logic [3:0] md);
        if (md[0] && s == E) return S;
        if (md[1] && s == M) return O;
        return s;
    endfunction

    // result: {next[2:0], ca, im, bc, txn[1:0], ch, di, sl}
    function automatic logic [10:0] model(logic [2:0] st, logic lv, logic [1:0] op,
                                          logic ch, logic sv, logic ca, logic im,
                                          logic bc, logic [3:0] md);
        logic [2:0] n = st;
        logic qca = 0, qim = 0, qbc = 0, rch = 0, rdi = 0, rsl = 0;
        logic [1:0] tx = 0;
        bit owned = (st == M || st == O);
        if (sv) begin
            if (st != I) begin
                if (!im) begin
                    rch = 1; rdi = owned;
                    if (ca) n = owned ? O : S;
                end else if (!bc) begin
                    rdi = owned;
                    if (ca || !owned) n = I;
                end else if (!ca && owned) rdi = 1;
                else if (md[3]) n = I;
                else begin n = S; rsl = 1; rch = 1; end
            end
            n = dem(n, md);
        end else if (lv) begin
            case (op)
                2'd0: if (st == I) begin qca = 1; tx = 1; n = ch ? S : E; end
                2'd1: begin
                    if (st == I) begin qca = 1; qim = 1; tx = 1; n = M; end
                    else if (st == M || st == E) n = M;
                    else if (md[2]) begin qca = 1; qim = 1; tx = 3; n = M; end
                    else begin qca = 1; qim = 1; qbc = 1; tx = 2; n = ch ? O : M; end
                end
                2'd2: begin
                    if (st == M) begin qca = 1; tx = 2; n = E; end
                    else if (st == O) begin qca = 1; tx = 2; n = ch ? S : E; end
                end
                default: begin if (owned) tx = 2; n = I; end
            endcase
            n = dem(n, md);
        end
        return {n, qca, qim, qbc, tx, rch, rdi, rsl};
    endfunction

    task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic lv, logic [1:0] op, logic ch, logic sv,
                        logic ca, logic im, logic bc, logic [3:0] md);
        logic [10:0] exp;
        @(negedge clk);
        lcl_valid = lv; lcl_op = op; bus_ch_in = ch; snp_valid = sv;
        snp_ca = ca; snp_im = im; snp_bc = bc; mode_i = md;
        #1;
        exp = model(mstate, lv, op, ch, sv, ca, im, bc, md);
        check(tag, {next_state_o, req_ca, req_im, req_bc, req_txn, rsp_ch, rsp_di, rsp_sl}, exp);
        @(posedge clk);
        mstate = exp[10:8];
        #1;
        check({tag, "/R1 state"}, {8'd0, state_o}, {8'd0, mstate});
    endtask

    function automatic string tag_of(logic lv, logic [1:0] op, logic sv,
                                     logic ca, logic im, logic bc, logic [2:0] st);
        if (sv && lv) return "R10";
        if (sv) begin
            if (st == I) return "R12";
            if (!im) return "R6";
            if (!bc) return ca ? "R7" : "R8";
            return "R9";
        end
        if (lv) begin
            if (op == 2'd0) return "R2";
            if (op == 2'd1) return (st == I) ? "R4" : "R3";
            return "R5";
        end
        return "R12";
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; lcl_valid = 0; lcl_op = 0; bus_ch_in = 0; snp_valid = 0;
        snp_ca = 0; snp_im = 0; snp_bc = 0; mode_i = 0;
        mstate = I;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1 reset", {8'd0, state_o}, {8'd0, I});
        check("R12 idle outputs", {req_ca, req_im, req_bc, req_txn, rsp_ch, rsp_di, rsp_sl},
              8'd0);

        step("R2 read miss no share", 1, 2'd0, 0, 0, 0, 0, 0, 4'd0);
        step("R2 read hit", 1, 2'd0, 1, 0, 0, 0, 0, 4'd0);
        step("R3 write E silent", 1, 2'd1, 0, 0, 0, 0, 0, 4'd0);
        step("R6 caching read of M", 0, 2'd0, 0, 1, 1, 0, 0, 4'd0);
        step("R3 broadcast write O", 1, 2'd1, 0, 0, 0, 0, 0, 4'd0);
        step("R5 push keep M", 1, 2'd2, 0, 0, 0, 0, 0, 4'd0);
        step("R8 noncaching write E", 0, 2'd0, 0, 1, 0, 1, 0, 4'd0);
        step("R12 snoop on invalid", 0, 2'd0, 0, 1, 1, 0, 0, 4'd0);
        step("R4 write miss", 1, 2'd1, 1, 0, 0, 0, 0, 4'd0);
        step("R10 collision", 1, 2'd3, 0, 1, 0, 1, 1, 4'd8);
        step("R8 owner captures", 0, 2'd0, 0, 1, 0, 1, 0, 4'd0);
        step("R7 read for modify", 0, 2'd0, 0, 1, 1, 1, 0, 4'd0);
        step("R11 demote E", 1, 2'd0, 0, 0, 0, 0, 0, 4'd1);
        step("R9 broadcast update", 0, 2'd0, 0, 1, 1, 1, 1, 4'd0);
        step("R3 claim", 1, 2'd1, 0, 0, 0, 0, 0, 4'd4);
        step("R9 snoop invalidate", 0, 2'd0, 0, 1, 1, 1, 1, 4'd8);
        step("R11 demote M", 1, 2'd1, 0, 0, 0, 0, 0, 4'd2);
        step("R5 push drop", 1, 2'd3, 0, 0, 0, 0, 0, 4'd0);
        step("R12 idle hold", 0, 2'd0, 0, 0, 0, 0, 0, 4'd0);

        for (int i = 0; i < 3000; i++) begin
            logic lv, sv, ch, ca, im, bc;
            logic [1:0] op;
            logic [3:0] md;
            lv = ($urandom % 100) < 60;
            sv = ($urandom % 100) < 40;
            op = 2'($urandom);
            ch = 1'($urandom);
            ca = 1'($urandom);
            im = 1'($urandom);
            bc = 1'($urandom);
            md = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
            step(tag_of(lv, op, sv, ca, im, bc, mstate), lv, op, ch, sv, ca, im, bc, md);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule